// File: doc/BRIEF.md
# SPI NOR Flash Command Sequencer

This block is the host-side master for a serial NOR flash on a SPI bus in mode 0. A request names an operation (read, page program or sector erase), a 24-bit byte address and a byte count. The block then runs the whole transaction on the bus. It opens with one or more status reads until the device reports that no write is in progress. For program and erase it next sends a write-enable command in a chip-select frame of its own. It then sends the command header and, for read or program, streams the data bytes inside that same frame.

Data moves on valid/ready streams. Program bytes arrive on `wr_valid`/`wr_ready`. A byte transfers on a clock edge where both are high. `wr_ready` does not depend on `wr_valid`. While `wr_valid` is low, the block holds the bus with SCLK low and chip select still asserted. Read bytes leave on `rd_valid`/`rd_ready`. Once `rd_valid` is raised, it and `rd_data` hold until `rd_ready` is seen, and no SCLK edges occur while the block waits. The request port follows the same handshake: `req_ready` is high only when the block is idle. `done` pulses for one cycle when an operation ends, and `timeout` is high in that same cycle if the status polling ran out.

Top module: `nor_seq`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, `req_ready` is 1 and `done` is 0.
- R2: Every operation starts with status-read frames. Each frame sends opcode 0x05 and then clocks in one status byte (MOSI sends 0x00) under a single chip-select assertion. The frames repeat while status bit 0 (write in progress) is 1. The block moves on after the first status byte with bit 0 equal to 0.
- R3: If MAX_POLLS status reads in a row return bit 0 set, the operation ends with `done` and `timeout` both 1. No write-enable or header frame follows.
- R4: For program and erase, the ready poll is followed by a frame that carries only the write-enable opcode 0x06, before the header frame.
- R5: The header is sent MSB first as the opcode followed by address bits 23:16, 15:8 and 7:0. `req_op` selects the opcode: 0 is read (0x03), 1 is program (0x02), and 2 or 3 is sector erase (0xD8).
- R6: An erase frame is exactly the 4 header bytes. The address is passed on unchanged, so any address inside a 64 KiB sector selects that sector.
- R7: A read clocks `req_len` bytes after the header in the same frame (MOSI sends 0x00) and delivers them in order on the read stream. While `rd_valid` is high, SCLK stays low. While `rd_valid` is high and `rd_ready` is low, `rd_data` is held.
- R8: A program sends `req_len` bytes from the write stream after the header in the same frame. While the block waits for `wr_valid`, SCLK stays low.
- R9: SPI mode 0 is used. SCLK idles low and MOSI changes only while SCLK is low. MISO is sampled on SCLK rising edges. Each SCLK high phase lasts `div_half`+1 clock cycles.
- R10: Between any two frames, `spi_cs_n` stays high for at least two SCLK periods, which is 4×(`div_half`+1) clock cycles.
- R11: `done` is a single-cycle pulse. After it, `req_ready` is 1 again. A length of 0 for read or program sends a header-only frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_half | input | DIV_W | SCLK half-period in clock cycles, minus one |
| req_valid | input | 1 | Operation request valid |
| req_ready | output | 1 | Block idle and accepting a request |
| req_op | input | 2 | 0 read, 1 program, 2/3 sector erase |
| req_addr | input | 24 | Flash byte address |
| req_len | input | LEN_W | Number of data bytes |
| wr_valid | input | 1 | Program byte valid |
| wr_ready | output | 1 | Block ready to take a program byte |
| wr_data | input | 8 | Program byte |
| rd_valid | output | 1 | Read byte valid |
| rd_ready | input | 1 | Consumer takes the read byte |
| rd_data | output | 8 | Read byte |
| done | output | 1 | Operation finished (one cycle) |
| timeout | output | 1 | Status polling gave up (with done) |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Data to flash |
| spi_miso | input | 1 | Data from flash |

## Verification
The hardest case to reach is the poll budget. It needs a device that reports busy for exactly the right number of status reads. The bench's flash model keeps a count of busy replies that the driver task loads before each operation. With MAX_POLLS reduced to 6, one erase sees 5 busy reads and must still proceed. A second run sees 10 busy reads and must stop after the sixth with a timeout. Back-pressure on both data streams is applied with duty patterns, so header bytes and data bytes are often separated by stalled cycles.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
  localparam logic [7:0] OPC_WREN  = 8'h06;
  localparam logic [7:0] OPC_RDSR  = 8'h05;
  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_PROG  = 8'h02;
  localparam logic [7:0] OPC_ERASE = 8'hD8;

  typedef enum logic [3:0] {
    S_IDLE, S_GAP, S_SR_CMD, S_SR_DATA, S_WREN,
    S_HDR, S_WDATA, S_RDATA, S_RHOLD, S_END
  } seq_state_t;
endpackage

// File: rtl/nor_byte_shift.sv
module nor_byte_shift #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_half,
  input  logic             start,
  input  logic [7:0]       tx,
  input  logic             miso,
  output logic             busy,
  output logic             done,
  output logic [7:0]       rx,
  output logic             sclk,
  output logic             mosi
);
  logic [DIV_W-1:0] cnt;
  logic [2:0]       bitn;
  logic [7:0]       sh;
  logic             busy_q, done_q, sclk_q;
  logic [7:0]       rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; done_q <= 1'b0; sclk_q <= 1'b0;
      cnt <= '0; bitn <= '0; sh <= '0; rx_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        busy_q <= 1'b1; sh <= tx; cnt <= '0; bitn <= '0; sclk_q <= 1'b0;
      end else if (busy_q) begin
        if (cnt == div_half) begin
          cnt <= '0;
          if (!sclk_q) begin
            sclk_q <= 1'b1;                 // rising: sample
            rx_q   <= {rx_q[6:0], miso};
          end else begin
            sclk_q <= 1'b0;                 // falling: shift
            if (bitn == 3'd7) begin
              busy_q <= 1'b0; done_q <= 1'b1;
            end else begin
              bitn <= bitn + 3'd1;
              sh   <= {sh[6:0], 1'b0};
            end
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign rx   = rx_q;
  assign sclk = sclk_q;
  assign mosi = sh[7];

  p_sclk_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sclk_q);
  p_mosi_hold_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q && $past(sclk_q)) |-> $stable(sh[7]));
endmodule

// File: rtl/nor_poll_count.sv
module nor_poll_count #(
  parameter int MAX_POLLS = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CNT_W = $clog2(MAX_POLLS + 1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  assign last = (cnt == CNT_W'(MAX_POLLS - 1));

  p_poll_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(MAX_POLLS));
endmodule

// File: rtl/nor_seq.sv
module nor_seq
  import nor_seq_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int LEN_W     = 12,
  parameter int MAX_POLLS = 100000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_half,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [23:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             done,
  output logic             timeout,
  output logic             spi_sclk,
  output logic             spi_cs_n,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  localparam int GAP_W = DIV_W + 3;

  seq_state_t       st, after_gap;
  logic [1:0]       op_q, hidx;
  logic [23:0]      addr_q;
  logic [LEN_W-1:0] left_q;
  logic             launched, err_q, rd_v_q;
  logic [7:0]       rd_d_q;
  logic [GAP_W-1:0] gap_cnt, gap_lim;
  logic             sh_start, sh_busy, sh_done, shifting;
  logic [7:0]       sh_tx, sh_rx, opcode;
  logic             poll_clr, poll_inc, poll_last, is_rd, is_er;

  assign is_rd   = (op_q == 2'b00);
  assign is_er   = op_q[1];
  assign opcode  = is_er ? OPC_ERASE : (is_rd ? OPC_READ : OPC_PROG);
  assign gap_lim = {1'b0, div_half, 2'b11};   // 4*(div+1)-1

  assign shifting = (st == S_SR_CMD) || (st == S_SR_DATA) || (st == S_WREN) ||
                    (st == S_HDR) || (st == S_WDATA) || (st == S_RDATA);
  assign wr_ready = (st == S_WDATA) && !launched;
  assign sh_start = shifting && !launched && !sh_busy &&
                    ((st != S_WDATA) || wr_valid);

  always_comb begin
    sh_tx = 8'h00;
    case (st)
      S_SR_CMD: sh_tx = OPC_RDSR;
      S_WREN:   sh_tx = OPC_WREN;
      S_WDATA:  sh_tx = wr_data;
      S_HDR: begin
        case (hidx)
          2'd0:    sh_tx = opcode;
          2'd1:    sh_tx = addr_q[23:16];
          2'd2:    sh_tx = addr_q[15:8];
          default: sh_tx = addr_q[7:0];
        endcase
      end
      default:  sh_tx = 8'h00;
    endcase
  end

  assign poll_clr = (st == S_IDLE) && req_valid;
  assign poll_inc = (st == S_SR_DATA) && sh_done && sh_rx[0] && !poll_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; after_gap <= S_IDLE; op_q <= '0; addr_q <= '0;
      left_q <= '0; hidx <= '0; launched <= 1'b0; err_q <= 1'b0;
      rd_v_q <= 1'b0; rd_d_q <= '0; gap_cnt <= '0;
    end else begin
      if (sh_start)     launched <= 1'b1;
      else if (sh_done) launched <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          op_q <= req_op; addr_q <= req_addr; left_q <= req_len;
          err_q <= 1'b0; gap_cnt <= '0;
          st <= S_GAP; after_gap <= S_SR_CMD;
        end
        S_GAP: begin
          if (gap_cnt == gap_lim) begin
            gap_cnt <= '0; st <= after_gap;
          end else gap_cnt <= gap_cnt + 1'b1;
        end
        S_SR_CMD: if (sh_done) st <= S_SR_DATA;
        S_SR_DATA: if (sh_done) begin
          if (!sh_rx[0]) begin
            st <= S_GAP; hidx <= '0;
            after_gap <= is_rd ? S_HDR : S_WREN;
          end else if (poll_last) begin
            err_q <= 1'b1; st <= S_END;
          end else begin
            st <= S_GAP; after_gap <= S_SR_CMD;
          end
        end
        S_WREN: if (sh_done) begin st <= S_GAP; after_gap <= S_HDR; end
        S_HDR: if (sh_done) begin
          hidx <= hidx + 2'd1;
          if (hidx == 2'd3) begin
            if (is_er || left_q == '0) st <= S_END;
            else st <= is_rd ? S_RDATA : S_WDATA;
          end
        end
        S_WDATA: if (sh_done) begin
          left_q <= left_q - 1'b1;
          if (left_q == LEN_W'(1)) st <= S_END;
        end
        S_RDATA: if (sh_done) begin
          rd_d_q <= sh_rx; rd_v_q <= 1'b1; st <= S_RHOLD;
        end
        S_RHOLD: if (rd_ready) begin
          rd_v_q <= 1'b0; left_q <= left_q - 1'b1;
          st <= (left_q == LEN_W'(1)) ? S_END : S_RDATA;
        end
        S_END:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  nor_byte_shift #(.DIV_W(DIV_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .div_half(div_half), .start(sh_start),
    .tx(sh_tx), .miso(spi_miso), .busy(sh_busy), .done(sh_done),
    .rx(sh_rx), .sclk(spi_sclk), .mosi(spi_mosi)
  );

  nor_poll_count #(.MAX_POLLS(MAX_POLLS)) u_polls (
    .clk(clk), .rst_n(rst_n), .clr(poll_clr), .inc(poll_inc), .last(poll_last)
  );

  assign req_ready = (st == S_IDLE);
  assign spi_cs_n  = !(shifting || st == S_RHOLD);
  assign rd_valid  = rd_v_q;
  assign rd_data   = rd_d_q;
  assign done      = (st == S_END);
  assign timeout   = (st == S_END) && err_q;

  p_sclk_in_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> !spi_cs_n);
  p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  p_rd_no_clock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !spi_sclk);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_timeout_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> spi_cs_n);
endmodule

// File: tb/nor_seq_tb_top.sv
`timescale 1ns/1ps
module nor_seq_tb_top;
  localparam int MAXP = 6;
  localparam int LW   = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [7:0] div_half = 8'd1;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_op = '0;
  logic [23:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic wr_valid = 1'b0, wr_ready;
  logic [7:0] wr_data = '0;
  logic rd_valid, rd_ready = 1'b1;
  logic [7:0] rd_data;
  logic done, timeout, spi_sclk, spi_cs_n, spi_mosi, spi_miso;

  nor_seq #(.DIV_W(8), .LEN_W(LW), .MAX_POLLS(MAXP)) dut_i (
    .clk(clk), .rst_n(rst_n), .div_half(div_half),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_len(req_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .done(done), .timeout(timeout), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard queues: bit 8 marks end of chip-select frame
  logic [8:0] exp_q[$];
  logic [7:0] rd_exp[$];
  logic [7:0] wr_src[$];

  // flash model
  int busy_left = 0;
  int fcnt = 0;
  logic [2:0] bcnt = '0;
  logic [7:0] shin = '0;
  logic [7:0] fb [0:63];
  logic [7:0] resp;
  always_comb begin
    resp = 8'h00;
    if (fcnt == 1 && fb[0] == 8'h05) resp = (busy_left > 0) ? 8'h03 : 8'h02;
    else if (fcnt >= 4 && fb[0] == 8'h03) resp = (fb[3] + 8'(fcnt - 4)) ^ 8'h3C;
  end
  assign spi_miso = resp[3'd7 - bcnt];

  always @(negedge spi_cs_n) if (rst_n) begin fcnt = 0; bcnt = '0; end

  always @(posedge spi_sclk) if (rst_n) begin
    logic [7:0] b;
    logic [8:0] e;
    b = {shin[6:0], spi_mosi};
    shin = b;
    bcnt = bcnt + 3'd1;
    if (bcnt == 3'd0) begin
      if (fcnt < 64) fb[fcnt] = b;
      fcnt = fcnt + 1;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 9'h1FF;
      chk(e == {1'b0, b}, "R2 R4 R5 R6 R7 R8 frame byte", b, e);
    end
  end

  always @(posedge spi_cs_n) if (rst_n) begin
    logic [8:0] e;
    e = (exp_q.size() > 0) ? exp_q.pop_front() : 9'h0EE;
    chk(e[8] && bcnt == 3'd0, "R2 R4 R6 frame end", {bcnt, e}, 9'h100);
    if (fcnt == 2 && fb[0] == 8'h05 && busy_left > 0) busy_left = busy_left - 1;
  end

  // timing monitors (R9, R10, R7, R8) sampled away from the active edge
  int hi_sclk = 0, hi_cs = 0;
  logic prev_sclk = 1'b0, prev_mosi = 1'b0, prev_rdv = 1'b0, prev_rdr = 1'b0;
  logic [7:0] prev_rdd = '0;
  bit rd_bp = 1'b0, wr_bp = 1'b0;
  bit wr_hs = 1'b0;

  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (spi_sclk) hi_sclk++;
    else if (hi_sclk > 0) begin
      chk(hi_sclk == div_half + 1, "R9 sclk high phase", hi_sclk, div_half + 1);
      hi_sclk = 0;
    end
    if (spi_sclk && prev_sclk && spi_mosi != prev_mosi)
      chk(1'b0, "R9 mosi moved while sclk high", spi_mosi, prev_mosi);
    if (spi_cs_n) hi_cs++;
    else if (hi_cs > 0) begin
      chk(hi_cs >= 4 * (div_half + 1), "R10 chip-select gap", hi_cs, 4 * (div_half + 1));
      hi_cs = 0;
    end
    if (prev_rdv && !prev_rdr)
      chk(rd_valid && rd_data == prev_rdd, "R7 read hold", rd_data, prev_rdd);
    if (rd_valid && spi_sclk) chk(1'b0, "R7 sclk while read pending", 1, 0);
    if (wr_ready && !wr_valid && spi_sclk) chk(1'b0, "R8 sclk while write starved", 1, 0);
    prev_sclk = spi_sclk; prev_mosi = spi_mosi;
    // read sink
    rd_ready = rd_bp ? (cyc % 3 == 1) : 1'b1;
    if (rd_valid && rd_ready) begin
      logic [7:0] e;
      e = (rd_exp.size() > 0) ? rd_exp.pop_front() : 8'hEE;
      chk(rd_data == e, "R7 read data", rd_data, e);
    end
    prev_rdv = rd_valid; prev_rdr = rd_ready; prev_rdd = rd_data;
    // write source
    if (wr_hs) begin
      void'(wr_src.pop_front());
      wr_valid = 1'b0; wr_hs = 1'b0;
    end
    if (!wr_valid && wr_src.size() > 0 && (!wr_bp || cyc % 4 == 0)) begin
      wr_valid = 1'b1; wr_data = wr_src[0];
    end
    if (wr_valid && wr_ready) wr_hs = 1'b1;
  end

  // watchdog
  always @(negedge clk) if (!finished && cyc > 150000) begin
    finished = 1'b1;
    chk(1'b0, "watchdog", cyc, 150000);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  function automatic logic [7:0] opc(input logic [1:0] op);
    return op[1] ? 8'hD8 : (op == 2'b00 ? 8'h03 : 8'h02);
  endfunction

  task automatic do_op(input logic [1:0] op, input logic [23:0] a, input int len,
                       input int busy, input bit exp_to);
    int np;
    busy_left = busy;
    np = (busy >= MAXP) ? MAXP : busy + 1;
    for (int p = 0; p < np; p++) begin
      exp_q.push_back(9'h005); exp_q.push_back(9'h000); exp_q.push_back(9'h100);
    end
    if (!exp_to) begin
      if (op != 2'b00) begin exp_q.push_back(9'h006); exp_q.push_back(9'h100); end
      exp_q.push_back({1'b0, opc(op)});
      exp_q.push_back({1'b0, a[23:16]});
      exp_q.push_back({1'b0, a[15:8]});
      exp_q.push_back({1'b0, a[7:0]});
      if (op == 2'b00) for (int i = 0; i < len; i++) begin
        exp_q.push_back(9'h000);
        rd_exp.push_back((a[7:0] + 8'(i)) ^ 8'h3C);
      end
      if (op == 2'b01) for (int i = 0; i < len; i++) begin
        logic [7:0] d;
        d = a[15:8] ^ 8'(i * 37 + 11);
        exp_q.push_back({1'b0, d});
        wr_src.push_back(d);
      end
      exp_q.push_back(9'h100);
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_len = LW'(len);
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && !finished) @(negedge clk);
    chk(timeout == exp_to, "R3 timeout flag at done", timeout, exp_to);
    chk(exp_q.size() == 0, "R2 R3 R4 all frames seen", exp_q.size(), 0);
    chk(rd_exp.size() == 0 && wr_src.size() == 0, "R7 R8 streams drained",
        rd_exp.size() + wr_src.size(), 0);
    @(negedge clk);
    chk(!done && req_ready, "R11 done pulse and ready", {done, req_ready}, 2'b01);
    exp_q.delete(); rd_exp.delete(); wr_src.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R1 bus idle in reset", {spi_cs_n, spi_sclk}, 2'b10);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !done && spi_cs_n && !spi_sclk, "R1 idle after reset",
        {req_ready, done, spi_cs_n, spi_sclk}, 4'b1010);
    do_op(2'b00, 24'h123456, 3, 0, 1'b0);          // R5 R7 plain read
    rd_bp = 1'b1;
    do_op(2'b00, 24'h00A0FE, 5, 2, 1'b0);          // R2 polls, R7 back-pressure
    wr_bp = 1'b1;
    do_op(2'b01, 24'hABCDEF, 4, 1, 1'b0);          // R4 R8 program with stalls
    do_op(2'b10, 24'h037F21, 0, 0, 1'b0);          // R6 erase mid-sector
    do_op(2'b10, 24'h7F0000, 0, 10, 1'b1);         // R3 timeout
    busy_left = 0;
    do_op(2'b11, 24'h05FFFF, 0, MAXP - 1, 1'b0);   // R3 boundary, R5 op 3 erase
    div_half = 8'd0;
    do_op(2'b00, 24'h400001, 1, 0, 1'b0);          // R9 fastest divider
    div_half = 8'd2;
    do_op(2'b01, 24'h00FF80, 2, 0, 1'b0);          // R9 slower divider
    do_op(2'b00, 24'h222222, 0, 0, 1'b0);          // R11 header-only read
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule